// File: doc/BRIEF.md
# Serial Bus Master Transmit Sequencer

This block walks one master-transmit frame of a two-wire home/car serial bus, one bit slot per strobe. A separate bit-waveform stage paces it with a one-cycle `bit_tick`. On each strobe the block presents the logical value of the next slot on `tx_bit`, and `slot_kind` tells what sort of slot that is. The frame is sent in a fixed field order: a start bit, the broadcast bit, a 12-bit master address, a 12-bit slave address, a 4-bit control field and an 8-bit telegraph length, followed by the data bytes. Every multi-bit field is sent MSB first and carries an even parity bit. The slave address, control, length and every data byte are also followed by an acknowledge slot, which is read from the slave.

A host starts a frame with `start_req`, which captures the header inputs. The host feeds data bytes through a one-deep holding register (`data_in` and `data_load`). The block gives the host single-cycle interrupt pulses: one when the header is complete, one for each byte it must supply, and one when the frame ends normally. A timing fault from the bit-timing checker, a not-acknowledged slot, or a byte that is missing when needed all abort the frame at once. The abort raises one error pulse with a code, and nothing more happens in that frame. The number of data bytes is the length field, where 0 means 256, capped at a per-frame maximum of 32 by default.

Top module: `mtx_sequencer`

## Requirements
- R1: After reset `tx_bit` is 1, `slot_kind` is 0, `busy` is 0, `err_code` is 0 and all four interrupt outputs are 0.
- R2: Slots follow this order. Start bit (value 1), broadcast bit, master address, parity, slave address, parity, ack, control, parity, ack, length, parity, ack, then for each byte: data, parity, ack. Every field is MSB first. `slot_kind` is 1 for a start, broadcast or field bit, 2 for a parity bit and 3 for an ack slot, and `tx_bit` is 1 in an ack slot.
- R3: Each parity bit makes the count of ones over its field plus the parity bit even.
- R4: `ack_in` is sampled on the strobe of each ack slot. 0 means acknowledged. A 1 aborts the frame with `err_code` 2.
- R5: On the strobe of the length field's acknowledge slot, `irq_start` pulses for one cycle.
- R6: `irq_data_req` pulses with `irq_start`, and again on the first bit of each data byte when more bytes remain after it.
- R7: If the holding register is empty on the first bit strobe of a data byte, the frame aborts with `err_code` 3 (underrun).
- R8: `timing_err` high in any cycle while busy aborts the frame in that cycle, tick or not, with `err_code` 1.
- R9: An abort pulses `irq_error` for one cycle, clears `busy` and sets `slot_kind` to 0. Later strobes in that frame raise no interrupt and give `slot_kind` 0.
- R10: The byte count is the length field, where 0 means 256, capped at MAX_BYTES. `irq_end` pulses and `busy` falls on the strobe of the last byte's acknowledge slot.
- R11: `start_req` while busy is ignored; the running frame keeps the header captured at its start.
- R12: With no `bit_tick` and no `timing_err`, `tx_bit` and `slot_kind` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per bit slot |
| start_req | input | 1 | Start a frame when idle; captures the header |
| bcast_in | input | 1 | Broadcast bit value |
| master_addr | input | MA_W | Master address |
| slave_addr | input | SA_W | Slave address |
| ctrl_in | input | CT_W | Control field |
| tlen_in | input | LEN_W | Telegraph length (0 means 256) |
| data_in | input | DATA_W | Byte for the holding register |
| data_load | input | 1 | Write `data_in` into the holding register |
| ack_in | input | 1 | Slave response in an ack slot (0 = ack) |
| timing_err | input | 1 | Timing fault from the bit-timing checker |
| tx_bit | output | 1 | Value of the slot just strobed |
| slot_kind | output | 2 | 0 none, 1 bit, 2 parity, 3 ack |
| busy | output | 1 | Frame in progress |
| irq_start | output | 1 | Header complete pulse |
| irq_data_req | output | 1 | Next byte wanted pulse |
| irq_end | output | 1 | Frame finished pulse |
| irq_error | output | 1 | Abort pulse |
| err_code | output | 2 | 0 none, 1 timing, 2 NACK, 3 underrun |

## Verification
The bench builds the block with MAX_BYTES set to 3 and all field widths at their defaults. With that cap, a zero length field (256 bytes) and a length of 5 both end after three bytes, so the cap and the end interrupt are reached in a few dozen strobes. A length of 2 still ends below the cap. The default widths keep the header layout that the bench walks bit by bit.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  typedef enum logic [2:0] {F_START, F_BCAST, F_MADDR, F_SADDR, F_CTRL, F_LEN, F_DATA} field_e;
  typedef enum logic [1:0] {PH_BITS, PH_PAR, PH_ACK} phase_e;
  typedef enum logic [1:0] {SK_NONE = 2'd0, SK_BIT = 2'd1, SK_PAR = 2'd2, SK_ACK = 2'd3} slot_e;
  typedef enum logic [1:0] {E_NONE = 2'd0, E_TIMING = 2'd1, E_NACK = 2'd2, E_UNDER = 2'd3} err_e;
endpackage

// File: rtl/mtx_holding.sv
module mtx_holding #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         consume,
  output logic [W-1:0] q,
  output logic         full
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      full <= 1'b0;
    end else begin
      if (load) q <= din;
      if (consume) full <= load;
      else if (load) full <= 1'b1;
    end
  end

  // a byte may only be taken while one is held
  p_take_full_r7: assert property (@(posedge clk) disable iff (rst) consume |-> full);
  // a write with no take leaves the register full
  p_load_sticks_r6: assert property (@(posedge clk) disable iff (rst) (load && !consume) |=> full);
endmodule

// File: rtl/mtx_byte_ctr.sv
module mtx_byte_ctr #(
  parameter int LEN_W     = 8,
  parameter int MAX_BYTES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [LEN_W-1:0] len,
  input  logic             inc,
  output logic             last
);
  localparam int CW = $clog2(MAX_BYTES + 1);

  logic [CW-1:0] cnt_q;
  logic [LEN_W:0] req;
  int total_i;

  always_comb begin
    req     = (len == '0) ? (LEN_W+1)'(1 << LEN_W) : {1'b0, len};
    total_i = (int'(req) > MAX_BYTES) ? MAX_BYTES : int'(req);
    last    = (int'(cnt_q) + 1 == total_i);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_cap_r10: assert property (@(posedge clk) disable iff (rst) int'(cnt_q) <= MAX_BYTES);
endmodule

// File: rtl/mtx_sequencer.sv
module mtx_sequencer
  import mtx_pkg::*;
#(
  parameter int MA_W      = 12,
  parameter int SA_W      = 12,
  parameter int CT_W      = 4,
  parameter int LEN_W     = 8,
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              start_req,
  input  logic              bcast_in,
  input  logic [MA_W-1:0]   master_addr,
  input  logic [SA_W-1:0]   slave_addr,
  input  logic [CT_W-1:0]   ctrl_in,
  input  logic [LEN_W-1:0]  tlen_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              data_load,
  input  logic              ack_in,
  input  logic              timing_err,
  output logic              tx_bit,
  output logic [1:0]        slot_kind,
  output logic              busy,
  output logic              irq_start,
  output logic              irq_data_req,
  output logic              irq_end,
  output logic              irq_error,
  output logic [1:0]        err_code
);
  localparam int W1    = (MA_W > SA_W) ? MA_W : SA_W;
  localparam int W2    = (CT_W > LEN_W) ? CT_W : LEN_W;
  localparam int W3    = (W2 > DATA_W) ? W2 : DATA_W;
  localparam int SH_W  = (W1 > W3) ? W1 : W3;
  localparam int CNT_W = $clog2(SH_W + 1);

  field_e            field_q;
  phase_e            phase_q;
  slot_e             slot_q;
  err_e              err_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SH_W-1:0]   sh_q;
  logic              par_q, busy_q, tx_q, bc_q;
  logic              irq_start_q, irq_req_q, irq_end_q, irq_err_q;
  logic [MA_W-1:0]   ma_q;
  logic [SA_W-1:0]   sa_q;
  logic [CT_W-1:0]   ct_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] hold_q;
  logic              hold_full, byte_last;
  logic              step, first_data, consume, underrun, byte_inc, bits_last, cur_bit, launch;
  slot_e             cur_kind;

  function automatic int fwidth(field_e f);
    case (f)
      F_MADDR: return MA_W;
      F_SADDR: return SA_W;
      F_CTRL:  return CT_W;
      F_LEN:   return LEN_W;
      F_DATA:  return DATA_W;
      default: return 1;
    endcase
  endfunction

  function automatic logic [SH_W-1:0] field_img(field_e f);
    case (f)
      F_MADDR: return SH_W'(ma_q) << (SH_W - MA_W);
      F_SADDR: return SH_W'(sa_q) << (SH_W - SA_W);
      F_CTRL:  return SH_W'(ct_q) << (SH_W - CT_W);
      F_LEN:   return SH_W'(len_q) << (SH_W - LEN_W);
      default: return '0;
    endcase
  endfunction

  mtx_holding #(.W(DATA_W)) hold_i (
    .clk(clk), .rst(rst), .load(data_load), .din(data_in),
    .consume(consume), .q(hold_q), .full(hold_full)
  );

  mtx_byte_ctr #(.LEN_W(LEN_W), .MAX_BYTES(MAX_BYTES)) ctr_i (
    .clk(clk), .rst(rst), .clear(launch), .len(len_q),
    .inc(byte_inc), .last(byte_last)
  );

  always_comb begin
    launch     = !busy_q && start_req;
    step       = busy_q && bit_tick && !timing_err;
    first_data = (phase_q == PH_BITS) && (field_q == F_DATA) && (cnt_q == '0);
    consume    = step && first_data && hold_full;
    underrun   = step && first_data && !hold_full;
    byte_inc   = step && (phase_q == PH_ACK) && (field_q == F_DATA) && !ack_in;
    bits_last  = (int'(cnt_q) == fwidth(field_q) - 1);
    cur_bit    = 1'b1;
    cur_kind   = SK_ACK;
    case (phase_q)
      PH_BITS: begin
        cur_kind = SK_BIT;
        if (field_q == F_START) cur_bit = 1'b1;
        else if (field_q == F_BCAST) cur_bit = bc_q;
        else if (first_data) cur_bit = hold_q[DATA_W-1];
        else cur_bit = sh_q[SH_W-1];
      end
      PH_PAR: begin
        cur_kind = SK_PAR;
        cur_bit  = par_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      field_q <= F_START;  phase_q <= PH_BITS;  slot_q <= SK_NONE;  err_q <= E_NONE;
      cnt_q <= '0;  sh_q <= '0;  par_q <= 1'b0;  busy_q <= 1'b0;  tx_q <= 1'b1;
      bc_q <= 1'b0;  ma_q <= '0;  sa_q <= '0;  ct_q <= '0;  len_q <= '0;
      irq_start_q <= 1'b0;  irq_req_q <= 1'b0;  irq_end_q <= 1'b0;  irq_err_q <= 1'b0;
    end else begin
      irq_start_q <= 1'b0;  irq_req_q <= 1'b0;  irq_end_q <= 1'b0;  irq_err_q <= 1'b0;
      if (!busy_q) begin
        if (bit_tick) slot_q <= SK_NONE;
        if (start_req) begin
          busy_q <= 1'b1;  err_q <= E_NONE;
          bc_q <= bcast_in;  ma_q <= master_addr;  sa_q <= slave_addr;
          ct_q <= ctrl_in;  len_q <= tlen_in;
          field_q <= F_START;  phase_q <= PH_BITS;  cnt_q <= '0;  par_q <= 1'b0;
        end
      end else if (timing_err) begin
        busy_q <= 1'b0;  slot_q <= SK_NONE;  irq_err_q <= 1'b1;  err_q <= E_TIMING;
      end else if (bit_tick) begin
        if (underrun) begin
          busy_q <= 1'b0;  slot_q <= SK_NONE;  irq_err_q <= 1'b1;  err_q <= E_UNDER;
        end else begin
          tx_q   <= cur_bit;
          slot_q <= cur_kind;
          case (phase_q)
            PH_BITS: begin
              par_q <= par_q ^ cur_bit;
              if (consume) begin
                sh_q <= (SH_W'(hold_q) << (SH_W - DATA_W)) << 1;
                if (!byte_last) irq_req_q <= 1'b1;
              end else begin
                sh_q <= sh_q << 1;
              end
              if (bits_last) begin
                cnt_q <= '0;
                if (field_q == F_START) begin
                  field_q <= F_BCAST;
                end else if (field_q == F_BCAST) begin
                  field_q <= F_MADDR;  par_q <= 1'b0;  sh_q <= field_img(F_MADDR);
                end else begin
                  phase_q <= PH_PAR;
                end
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            PH_PAR: begin
              if (field_q == F_MADDR) begin
                field_q <= F_SADDR;  phase_q <= PH_BITS;  par_q <= 1'b0;  sh_q <= field_img(F_SADDR);
              end else begin
                phase_q <= PH_ACK;
              end
            end
            default: begin
              if (ack_in) begin
                busy_q <= 1'b0;  slot_q <= SK_NONE;  irq_err_q <= 1'b1;  err_q <= E_NACK;
              end else begin
                phase_q <= PH_BITS;  par_q <= 1'b0;  cnt_q <= '0;
                case (field_q)
                  F_SADDR: begin field_q <= F_CTRL; sh_q <= field_img(F_CTRL); end
                  F_CTRL:  begin field_q <= F_LEN;  sh_q <= field_img(F_LEN);  end
                  F_LEN: begin
                    field_q <= F_DATA;  sh_q <= '0;
                    irq_start_q <= 1'b1;  irq_req_q <= 1'b1;
                  end
                  default: begin
                    field_q <= F_DATA;  sh_q <= '0;
                    if (byte_last) begin
                      busy_q <= 1'b0;  irq_end_q <= 1'b1;
                    end
                  end
                endcase
              end
            end
          endcase
        end
      end
    end
  end

  assign tx_bit       = tx_q;
  assign slot_kind    = slot_q;
  assign busy         = busy_q;
  assign irq_start    = irq_start_q;
  assign irq_data_req = irq_req_q;
  assign irq_end      = irq_end_q;
  assign irq_error    = irq_err_q;
  assign err_code     = err_q;

  // an error pulse always leaves the sequencer idle
  p_err_idle_r9: assert property (@(posedge clk) disable iff (rst) irq_err_q |-> !busy_q);
  // an idle sequencer produces no interrupt on the next cycle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !busy_q |=> !(irq_start_q || irq_req_q || irq_end_q || irq_err_q));
  // start, end and error pulses never coincide
  p_irq_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_start_q, irq_end_q, irq_err_q}));
  // header completion also asks for the first byte
  p_start_req_r5: assert property (@(posedge clk) disable iff (rst) irq_start_q |-> irq_req_q);
  // outputs move only on a strobe or a timing fault
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!bit_tick && !timing_err) |=> ($stable(tx_q) && $stable(slot_q)));
  // a running frame's header stays put whatever start_req does
  p_hdr_keep_r11: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> ($stable(ma_q) && $stable(len_q)));
endmodule

// File: tb/mtx_sequencer_tb.sv
`timescale 1ns/1ps
module mtx_sequencer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 0, start_req = 0, bcast_in = 0, data_load = 0, ack_in = 0, timing_err = 0;
  logic [11:0] master_addr = '0, slave_addr = '0;
  logic [3:0]  ctrl_in = '0;
  logic [7:0]  tlen_in = '0, data_in = '0;
  logic tx_bit, busy, irq_start, irq_data_req, irq_end, irq_error;
  logic [1:0] slot_kind, err_code;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mtx_sequencer #(.MAX_BYTES(3)) dut_i (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .start_req(start_req), .bcast_in(bcast_in),
    .master_addr(master_addr), .slave_addr(slave_addr), .ctrl_in(ctrl_in), .tlen_in(tlen_in),
    .data_in(data_in), .data_load(data_load), .ack_in(ack_in), .timing_err(timing_err),
    .tx_bit(tx_bit), .slot_kind(slot_kind), .busy(busy), .irq_start(irq_start),
    .irq_data_req(irq_data_req), .irq_end(irq_end), .irq_error(irq_error), .err_code(err_code)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic ackv);
    @(negedge clk); ack_in = ackv; bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0; ack_in = 1'b0;
  endtask

  task automatic load(input logic [7:0] b);
    @(negedge clk); data_in = b; data_load = 1'b1;
    @(negedge clk); data_load = 1'b0;
  endtask

  task automatic pulse_timing();
    @(negedge clk); timing_err = 1'b1;
    @(negedge clk); timing_err = 1'b0;
  endtask

  task automatic begin_frame(input logic bc, input logic [11:0] ma, input logic [11:0] sa,
                             input logic [3:0] ct, input logic [7:0] ln);
    @(negedge clk);
    bcast_in = bc; master_addr = ma; slave_addr = sa; ctrl_in = ct; tlen_in = ln; start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    check("R2 busy after start", busy, 1);
  endtask

  task automatic send_field(input logic [31:0] v, input int w, input string tag);
    logic p = 1'b0;
    for (int i = w - 1; i >= 0; i--) begin
      tick(1'b0);
      check({tag, " R2 kind"}, slot_kind, 1);
      check({tag, " R2 bit"}, tx_bit, v[i]);
      p ^= v[i];
    end
    tick(1'b0);
    check({tag, " R3 parity kind"}, slot_kind, 2);
    check({tag, " R3 parity"}, tx_bit, p);
  endtask

  task automatic ack_ok(input string tag);
    tick(1'b0);
    check({tag, " R4 ack kind"}, slot_kind, 3);
    check({tag, " R4 ack bit"}, tx_bit, 1);
    check({tag, " R5 no early start"}, irq_start, 0);
  endtask

  task automatic header(input logic bc, input logic [11:0] ma, input logic [11:0] sa,
                        input logic [3:0] ct, input logic [7:0] ln);
    begin_frame(bc, ma, sa, ct, ln);
    tick(1'b0); check("R2 start bit kind", slot_kind, 1); check("R2 start bit", tx_bit, 1);
    tick(1'b0); check("R2 bcast", tx_bit, bc);
    send_field(ma, 12, "maddr");
    send_field(sa, 12, "saddr"); ack_ok("saddr");
    send_field(ct, 4, "ctrl");   ack_ok("ctrl");
    send_field(ln, 8, "len");
    tick(1'b0);
    check("R5 irq_start", irq_start, 1);
    check("R6 first request", irq_data_req, 1);
    check("R5 still busy", busy, 1);
  endtask

  task automatic data_byte(input logic [7:0] b, input logic exp_req, input logic is_last);
    logic p = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(1'b0);
      check("R2 data kind", slot_kind, 1);
      check("R2 data bit", tx_bit, b[i]);
      if (i == 7) check("R6 data request", irq_data_req, exp_req);
      p ^= b[i];
    end
    tick(1'b0);
    check("R3 data parity", tx_bit, p);
    tick(1'b0);
    check("R4 data ack kind", slot_kind, 3);
    check("R10 irq_end", irq_end, is_last);
    check("R10 busy", busy, !is_last);
  endtask

  task automatic quiet_after_abort();
    for (int i = 0; i < 2; i++) begin
      tick(1'b0);
      check("R9 slot idle", slot_kind, 0);
      check("R9 no irq", {irq_start, irq_data_req, irq_end, irq_error}, 0);
    end
  endtask

  task automatic t_reset();
    check("R1 tx", tx_bit, 1);
    check("R1 kind", slot_kind, 0);
    check("R1 busy", busy, 0);
    check("R1 err", err_code, 0);
    check("R1 irqs", {irq_start, irq_data_req, irq_end, irq_error}, 0);
  endtask

  task automatic t_normal();
    header(1'b0, 12'hA5C, 12'h3B1, 4'h9, 8'd2);
    load(8'hC3); data_byte(8'hC3, 1'b1, 1'b0);
    load(8'h5A); data_byte(8'h5A, 1'b0, 1'b1);
    check("R10 no error", err_code, 0);
  endtask

  task automatic t_len_zero();
    header(1'b1, 12'h001, 12'hFFE, 4'h0, 8'd0);
    load(8'h81); data_byte(8'h81, 1'b1, 1'b0);
    load(8'h7E); data_byte(8'h7E, 1'b1, 1'b0);
    load(8'hFF); data_byte(8'hFF, 1'b0, 1'b1);
  endtask

  task automatic t_len_cap();
    header(1'b0, 12'h800, 12'h010, 4'hF, 8'd5);
    load(8'h01); data_byte(8'h01, 1'b1, 1'b0);
    load(8'h02); data_byte(8'h02, 1'b1, 1'b0);
    load(8'h03); data_byte(8'h03, 1'b0, 1'b1);
  endtask

  task automatic t_nack();
    begin_frame(1'b1, 12'h123, 12'h456, 4'h5, 8'd1);
    tick(1'b0); tick(1'b0);
    send_field(12'h123, 12, "maddr");
    send_field(12'h456, 12, "saddr"); ack_ok("saddr");
    send_field(4'h5, 4, "ctrl");
    tick(1'b1);
    check("R4 nack irq", irq_error, 1);
    check("R4 nack code", err_code, 2);
    check("R9 busy cleared", busy, 0);
    check("R9 slot cleared", slot_kind, 0);
    quiet_after_abort();
  endtask

  task automatic t_underrun();
    header(1'b0, 12'h0F0, 12'h00F, 4'h3, 8'd1);
    tick(1'b0);
    check("R7 underrun irq", irq_error, 1);
    check("R7 underrun code", err_code, 3);
    check("R9 busy cleared", busy, 0);
    quiet_after_abort();
  endtask

  task automatic t_timing();
    begin_frame(1'b0, 12'hABC, 12'hDEF, 4'h1, 8'd1);
    tick(1'b0); tick(1'b0); tick(1'b0);
    pulse_timing();
    check("R8 timing irq", irq_error, 1);
    check("R8 timing code", err_code, 1);
    check("R8 busy cleared", busy, 0);
    quiet_after_abort();
  endtask

  task automatic t_start_ignored();
    begin_frame(1'b1, 12'hA5C, 12'h222, 4'h2, 8'd1);
    tick(1'b0);
    @(negedge clk); bcast_in = 1'b0; master_addr = 12'h0FF; start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    tick(1'b0); check("R11 bcast kept", tx_bit, 1);
    send_field(12'hA5C, 12, "R11 maddr kept");
    pulse_timing();
    check("R11 abort to idle", busy, 0);
  endtask

  task automatic t_stall();
    logic t0;
    logic [1:0] k0;
    begin_frame(1'b0, 12'h555, 12'h111, 4'h4, 8'd1);
    tick(1'b0); tick(1'b0);
    t0 = tx_bit; k0 = slot_kind;
    repeat (20) @(negedge clk);
    check("R12 tx held", tx_bit, t0);
    check("R12 kind held", slot_kind, k0);
    check("R12 still busy", busy, 1);
    tick(1'b0);
    check("R12 resumes with maddr msb", tx_bit, 0);
    pulse_timing();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_len_zero();
    t_len_cap();
    t_nack();
    t_underrun();
    t_timing();
    t_start_ignored();
    t_stall();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule